// File: doc/BRIEF.md
# Compressed-Setting Feedback Divider

This block is the programmable divider in the feedback path of a frequency synthesizer. It receives the oscillator signal after a fixed divide-by-64 prescaler, counts its rising edges, and produces a divided clock and a terminal-count strobe once every N input cycles. A phase comparator takes these outputs and compares them with a 390.625 Hz reference. When the loop is locked, N = 4000 puts the carrier at 100 MHz, and each 100 kHz channel step adds 4 to N.

N is 13 bits wide, but it is selected by a 10-bit setting word. Every legal ratio has bits 10 and 11 equal, and a single setting bit drives both. Bits 0 and 1 of every legal ratio are zero, so the setting does not carry them. A setting that decodes to a ratio outside 3500..4320 is flagged as out of range, and the divider keeps the last valid ratio. A new ratio is applied only at a terminal count, so an output period is never cut short.

Top module: `fbdiv_top`

## Requirements
- R1: The setting word s[9:0] expands to N = s[9]·4096 + s[8]·(2048+1024) + s[7:0]·4. The two lowest ratio bits are therefore always zero, and ratio bits 11 and 10 both equal s[8].
- R2: While reset is asserted and in the first cycle after release, tc_o is 0, div_clk_o is 1 and range_err_o is 0. The divider starts with N = 4000, and the first tc_o pulse comes 3999 rising edges after reset is released.
- R3: After the first one, consecutive tc_o pulses are exactly N input cycles apart. No cycle is added or lost when the counter reloads.
- R4: tc_o is high for exactly one input cycle per period.
- R5: div_clk_o is low in the cycle in which tc_o is high. It is high for the N/2 cycles that follow that cycle and low for the next N/2 cycles.
- R6: A setting that decodes to a ratio below 3500 or above 4320 sets range_err_o on the next rising edge. The ratio in effect does not change, and later periods use the last valid ratio.
- R7: A new setting takes effect only at a terminal count. If the setting changes during the cycle in which tc_o is high, the period that follows still uses the old ratio, and the period after that uses the new one.
- R8: The bounds are inclusive. Setting 363 (N = 3500) and setting 568 (N = 4320) are both accepted. Setting 362 (N = 3496) and setting 569 (N = 4324) are both rejected.
- R9: range_err_o returns to 0 one edge after a setting in the legal range is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaled oscillator clock that is counted |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released on a falling clock edge |
| setting_i | input | 10 | Compressed ratio setting |
| div_clk_o | output | 1 | Divided clock sent to the phase comparator |
| tc_o | output | 1 | One-cycle terminal-count strobe |
| range_err_o | output | 1 | Set when the current setting decodes to an illegal ratio |

## Verification
The assertions assume that setting_i changes only away from the rising edge of clk_i and that reset is released away from that edge. The bench therefore drives every setting change and the reset release on the falling edge. The checks that a ratio stays within its limits and that the active ratio stays stable between terminal counts assume that the reset ratio is itself legal. The bench changes settings during a terminal-count cycle, so every applied ratio shows up as a full measured period. Legal and illegal random settings are mixed with the four boundary settings and with the all-zero and all-one words.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int SET_W   = 10;
  localparam int RATIO_W = 13;
  localparam int LOW_W   = 8;

  typedef logic [SET_W-1:0]   setting_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  localparam ratio_t RATIO_MIN = ratio_t'(3500);
  localparam ratio_t RATIO_MAX = ratio_t'(4320);
  localparam ratio_t RATIO_RST = ratio_t'(4000);

  // Top setting bit -> ratio bit 12; next bit -> ratio bits 11 and 10;
  // low byte -> ratio bits 9..2; ratio bits 1..0 are zero.
  function automatic ratio_t expand_setting(setting_t s);
    ratio_t r;
    r = '0;
    r[RATIO_W-1]       = s[SET_W-1];
    r[RATIO_W-2]       = s[SET_W-2];
    r[RATIO_W-3]       = s[SET_W-2];
    r[LOW_W+1:2]       = s[LOW_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/fbdiv_decode.sv
module fbdiv_decode
  import fbdiv_pkg::*;
#(
  parameter ratio_t MIN_RATIO = RATIO_MIN,
  parameter ratio_t MAX_RATIO = RATIO_MAX
) (
  input  setting_t setting_i,
  output ratio_t   ratio_o,
  output logic     legal_o
);
  ratio_t expanded;

  always_comb begin
    expanded = expand_setting(setting_i);
    ratio_o  = expanded;
    legal_o  = (expanded >= MIN_RATIO) && (expanded <= MAX_RATIO);
  end
endmodule

// File: rtl/fbdiv_hold.sv
module fbdiv_hold
  import fbdiv_pkg::*;
#(
  parameter ratio_t RST_RATIO = RATIO_RST
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t cand_i,
  input  logic   legal_i,
  output ratio_t held_o,
  output logic   err_o
);
  ratio_t held_q, held_d;
  logic   err_q, err_d;
  logic   held_en;

  always_comb begin
    held_en = legal_i;
    held_d  = held_en ? cand_i : held_q;
    err_d   = ~legal_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= RST_RATIO;
      err_q  <= 1'b0;
    end else begin
      held_q <= held_d;
      err_q  <= err_d;
    end
  end

  assign held_o = held_q;
  assign err_o  = err_q;
endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter
  import fbdiv_pkg::*;
#(
  parameter ratio_t RST_RATIO = RATIO_RST
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t ratio_i,
  output ratio_t active_o,
  output logic   tc_o,
  output logic   div_o
);
  localparam ratio_t ONE = ratio_t'(1);

  ratio_t cnt_q, cnt_d;
  ratio_t act_q, act_d;
  logic   div_q, div_d;
  logic   at_tc;

  always_comb begin
    at_tc = (cnt_q == '0);
    if (at_tc) begin
      cnt_d = ratio_i - ONE;
      act_d = ratio_i;
    end else begin
      cnt_d = cnt_q - ONE;
      act_d = act_q;
    end
    div_d = (cnt_d >= (act_d >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_RATIO - ONE;
      act_q <= RST_RATIO;
      div_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      div_q <= div_d;
    end
  end

  assign active_o = act_q;
  assign tc_o     = at_tc;
  assign div_o    = div_q;
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter ratio_t MIN_RATIO = RATIO_MIN,
  parameter ratio_t MAX_RATIO = RATIO_MAX,
  parameter ratio_t RST_RATIO = RATIO_RST
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SET_W-1:0]      setting_i,
  output logic                  div_clk_o,
  output logic                  tc_o,
  output logic                  range_err_o
);
  ratio_t cand_ratio;
  logic   cand_legal;
  ratio_t hold_ratio;
  ratio_t act_ratio;

  fbdiv_decode #(
    .MIN_RATIO (MIN_RATIO),
    .MAX_RATIO (MAX_RATIO)
  ) u_decode (
    .setting_i (setting_i),
    .ratio_o   (cand_ratio),
    .legal_o   (cand_legal)
  );

  fbdiv_hold #(
    .RST_RATIO (RST_RATIO)
  ) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cand_i  (cand_ratio),
    .legal_i (cand_legal),
    .held_o  (hold_ratio),
    .err_o   (range_err_o)
  );

  fbdiv_counter #(
    .RST_RATIO (RST_RATIO)
  ) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ratio_i  (hold_ratio),
    .active_o (act_ratio),
    .tc_o     (tc_o),
    .div_o    (div_clk_o)
  );
endmodule

// File: rtl/fbdiv_checker.sv
module fbdiv_checker
  import fbdiv_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   tc_o,
  input logic   div_clk_o,
  input logic   range_err_o,
  input ratio_t hold_ratio,
  input ratio_t act_ratio
);
  // R1: stored ratio has equal bits 11/10 and zero low bits
  p_ratio_shape_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_ratio[11] == hold_ratio[10]) && (hold_ratio[1:0] == 2'b00));

  // R4: strobe lasts one cycle
  p_tc_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o);

  // R5: divided clock low during terminal count, high right after it
  p_div_low_at_tc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> !div_clk_o);
  p_div_high_after_tc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> div_clk_o);

  // R6: a rejected setting leaves the held ratio untouched
  p_err_keeps_ratio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |-> $stable(hold_ratio));

  // R7: active ratio changes only across a terminal count
  p_switch_at_tc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_o |=> $stable(act_ratio));

  // R8: active ratio always within legal bounds
  p_active_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ratio >= RATIO_MIN) && (act_ratio <= RATIO_MAX));
endmodule

bind fbdiv_top fbdiv_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tc_o        (tc_o),
  .div_clk_o   (div_clk_o),
  .range_err_o (range_err_o),
  .hold_ratio  (hold_ratio),
  .act_ratio   (act_ratio)
);

// File: tb/fbdiv_top_test.sv
module fbdiv_top_test;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [9:0] setting;
  logic       div_clk_o, tc_o, range_err_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  fbdiv_top uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .setting_i   (setting),
    .div_clk_o   (div_clk_o),
    .tc_o        (tc_o),
    .range_err_o (range_err_o)
  );

  function automatic int ref_ratio(logic [9:0] s);
    return (s[9] ? 4096 : 0) + (s[8] ? 3072 : 0) + 4 * int'(s[7:0]);
  endfunction

  function automatic bit ref_legal(logic [9:0] s);
    int n = ref_ratio(s);
    return (n >= 3500) && (n <= 4320);
  endfunction

  function automatic logic [9:0] encode(int n);
    logic [12:0] b = 13'(n);
    return {b[12], b[10], b[9:2]};
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts negedges up to and including the next one with tc_o high.
  task automatic measure(input int cyc0, input int hi0, output int cyc, output int hi);
    cyc = cyc0;
    hi  = hi0;
    do begin
      @(negedge clk);
      cyc++;
      if (div_clk_o) hi++;
    end while (!tc_o);
  endtask

  // Called at the negedge of a tc cycle; applies s, checks flag and the two periods.
  int pend;
  task automatic trial(logic [9:0] s);
    int cyc, hi, exp_now;
    bit lg;
    exp_now = pend;
    lg = ref_legal(s);
    setting = s;
    @(negedge clk);
    check("R6/R9 range_err_o", int'(range_err_o), lg ? 0 : 1);
    check("R4 tc_o low after strobe", int'(tc_o), 0);
    measure(1, div_clk_o ? 1 : 0, cyc, hi);
    check("R7/R3 period with previous ratio", cyc, exp_now);
    check("R5 high cycles", hi, exp_now / 2);
    if (lg) pend = ref_ratio(s);
  endtask

  initial begin
    int cyc, hi;
    void'($urandom(32'h5eed));
    rst_ni  = 1'b0;
    setting = encode(4000);
    check("R1 encode round trip", ref_ratio(encode(4000)), 4000);
    repeat (3) @(negedge clk);
    check("R2 tc_o in reset", int'(tc_o), 0);
    check("R2 div_clk_o in reset", int'(div_clk_o), 1);
    check("R2 range_err_o in reset", int'(range_err_o), 0);
    rst_ni = 1'b1;
    measure(0, 0, cyc, hi);
    check("R2 first strobe delay", cyc, 3999);
    check("R2 first window high cycles", hi, 1999);
    pend = 4000;

    // R8 boundaries, R6 rejects, R1 mapping extremes
    trial(10'd363);
    trial(10'd568);
    trial(10'd362);
    trial(10'd569);
    trial(10'd0);
    trial(10'd1023);
    trial(10'd488);
    for (int i = 0; i < 18; i++) begin
      if (i % 3 == 2) trial(10'($urandom_range(0, 1023)));
      else            trial(encode(3500 + 4 * int'($urandom_range(0, 205))));
    end
    // final period shows the last pending ratio (R3)
    measure(0, 0, cyc, hi);
    check("R3 steady period", cyc, pend);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule